// File: doc/BRIEF.md
# Network Controller Interrupt Cause Aggregator

This block collects interrupt causes for a multi-queue network controller and decides how they reach the host. It keeps two cause registers. The legacy cause register has a mask and an auto-mask. The extended cause register is indexed by vector number and has its own mask and auto-clear set. A control bit chooses between two delivery modes. In per-vector mode, each extended cause bit fires its own one-cycle pulse. In single-line mode, one level-sensitive line follows the unmasked legacy causes.

Hardware raises causes on a pulse bus. Software reaches every register through a write strobe and a read strobe, each with a 4-bit register select. Read data is combinational from the selected register. A read has side effects only when its strobe is high. A route register lets legacy causes reach the extended register in per-vector mode: it holds one 8-bit allocation byte per cause group. In single-line mode, a fixed OTHER bit in the extended register summarises the legacy causes. A separate throttle register stores a sanitised interval value.

Top module: `intr_cause_agg`

## Requirements
- R1: The design ORs causes into the legacy cause register. They arrive on `raise_in` or through a write to select 1. A write to select 0 clears the legacy cause bits that are set in `wr_data`. Every register starts at zero after reset.
- R2: Bit 31 of the legacy cause register is a summary bit. In every cycle it equals the OR of bits 30:0.
- R3: In single-line mode, `irq_line` is high while the legacy causes and the legacy mask (select 2) share a set bit. In per-vector mode it is low. A write to select 2 sets mask bits. A write to select 3 clears mask bits.
- R4: In single-line mode, a legacy cause that becomes both set and unmasked in a cycle sets bit 31 (OTHER) of the extended cause register (select 5).
- R5: A lowering event is a legacy cause clear, a mask clear or a clearing read. In single-line mode, if no unmasked legacy cause remains after such an event, OTHER is cleared.
- R6: In per-vector mode, a newly set and unmasked legacy cause is routed through the route register (select 9). Causes in bits 15:0 use byte 0 and causes in bits 30:16 use byte 1. A byte sets extended bit `byte[4:0]` only when its bit 7 is 1.
- R7: In per-vector mode, each extended bit that becomes set and unmasked (mask at select 6, clear at select 7) pulses the matching `vec_fire` bit for one cycle. The pulse appears in the cycle after the cause arrives. No pulse occurs in single-line mode. A write to select 5 clears the extended cause bits that are set in `wr_data`.
- R8: When a vector fires, the extended cause bit is cleared if its bit is set in the auto-clear register (select 8). Otherwise it stays set.
- R9: A read strobe on select 0 with bit 1 of the control register (select 10) low works as follows. The register is cleared if the mask is zero or the summary bit is set. In the summary-bit case, with a nonzero mask, the auto-mask bits (select 4) are also removed from the mask.
- R10: With control bit 1 high, a read strobe on select 0 always clears the legacy cause register and leaves the mask unchanged.
- R11: A write to the throttle register (select 11) stores only bits 14:1 of `wr_data`.
- R12: A cause that is already pending is not newly raised, so it neither routes nor fires again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_in | input | 32 | Hardware cause-raise pulses for the legacy cause register |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; enables read side effects |
| rd_sel | input | 4 | Register select for reads |
| rd_data | output | 32 | Value of the selected register |
| irq_line | output | 1 | Single-line interrupt level |
| vec_fire | output | 32 | Per-vector one-cycle fire pulses |

## Verification
The assertions take some facts about the inputs for granted. A clearing read of the legacy register is assumed not to coincide with a new raise. A mask-clear write is assumed not to share its cycle with a mask-set write. Fire pulses are taken to come only from the mode seen in the previous cycle. The stimulus applies one operation per cycle: a write, a raise or a read. It leaves idle cycles between operations, so these conditions always hold. The stimulus also checks state by driving `rd_sel` with `rd_en` low, which leaves read-clear side effects untouched.

// File: rtl/intr_cause_agg_pkg.sv
package intr_cause_agg_pkg;

    localparam int CW    = 32;
    localparam int IDX_W = $clog2(CW);
    localparam int NGRP  = 2;
    localparam int RT_W  = 8 * NGRP;

    typedef enum logic [3:0] {
        SEL_LC      = 4'd0,
        SEL_LC_SET  = 4'd1,
        SEL_LM      = 4'd2,
        SEL_LM_CLR  = 4'd3,
        SEL_LAM     = 4'd4,
        SEL_VC      = 4'd5,
        SEL_VM      = 4'd6,
        SEL_VM_CLR  = 4'd7,
        SEL_VAC     = 4'd8,
        SEL_RT      = 4'd9,
        SEL_CTRL    = 4'd10,
        SEL_THR     = 4'd11
    } reg_sel_e;

    typedef struct packed {
        logic [CW-1:0]   lc;
        logic [CW-1:0]   lm;
        logic [CW-1:0]   lam;
        logic [CW-1:0]   vc;
        logic [CW-1:0]   vm;
        logic [CW-1:0]   vac;
        logic [RT_W-1:0] rt;
        logic            vmode;
        logic            corr;
        logic [CW-1:0]   thr;
        logic [CW-1:0]   fire;
    } agg_state_t;

endpackage

// File: rtl/intr_cause_agg_route.sv
module intr_cause_agg_route
    import intr_cause_agg_pkg::*;
#(
    parameter logic [CW-1:0] GRP0_MASK = 32'h0000_FFFF,
    parameter logic [CW-1:0] GRP1_MASK = 32'h7FFF_0000
) (
    input  logic            en,
    input  logic [CW-1:0]   raised,
    input  logic [RT_W-1:0] rt,
    output logic [CW-1:0]   set_bits
);

    logic [CW-1:0] grp_set [NGRP];

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam logic [CW-1:0] GM = (g == 0) ? GRP0_MASK : GRP1_MASK;
        logic             valid;
        logic [IDX_W-1:0] idx;
        logic [1:0]       unused_rsv;
        assign valid      = rt[8*g + 7];
        assign idx        = rt[8*g +: IDX_W];
        assign unused_rsv = rt[8*g + 5 +: 2];
        assign grp_set[g] = (en && valid && (|(raised & GM)))
                            ? (CW'(1) << idx) : '0;
    end

    always_comb begin
        set_bits = '0;
        for (int g = 0; g < NGRP; g++) begin
            set_bits = set_bits | grp_set[g];
        end
    end

endmodule

// File: rtl/intr_cause_agg_legacy.sv
module intr_cause_agg_legacy
    import intr_cause_agg_pkg::*;
#(
    parameter int SUM_BIT = 31
) (
    input  logic [CW-1:0] lc_q,
    input  logic [CW-1:0] lm_q,
    input  logic [CW-1:0] lam_q,
    input  logic [CW-1:0] raise_all,
    input  logic [CW-1:0] w1c,
    input  logic [CW-1:0] mset,
    input  logic [CW-1:0] mclr,
    input  logic          rd_req,
    input  logic          corr,
    output logic [CW-1:0] lc_d,
    output logic [CW-1:0] lm_d,
    output logic [CW-1:0] raised_new,
    output logic          lowered,
    output logic          none_unmasked
);

    localparam logic [CW-1:0] SUM_M = CW'(1) << SUM_BIT;

    logic          summary;
    logic          clr_rd;
    logic          amask;
    logic [CW-1:0] base;
    logic [CW-1:0] raw;

    always_comb begin
        summary = lc_q[SUM_BIT];
        clr_rd  = rd_req && (corr || (lm_q == '0) || summary);
        amask   = rd_req && !corr && (lm_q != '0) && summary;
        base    = clr_rd ? '0 : (lc_q & ~w1c);
        raw     = (base | raise_all) & ~SUM_M;
        lc_d    = raw | ((|raw) ? SUM_M : '0);
        lm_d    = (lm_q | mset) & ~mclr;
        if (amask) begin
            lm_d = lm_d & ~lam_q;
        end
        raised_new    = raw & lm_d & ~(lc_q & lm_q);
        lowered       = clr_rd || (|w1c) || (|mclr);
        none_unmasked = ((raw & lm_d) == '0);
    end

endmodule

// File: rtl/intr_cause_agg.sv
module intr_cause_agg
    import intr_cause_agg_pkg::*;
#(
    parameter logic [CW-1:0] GRP0_MASK = 32'h0000_FFFF,
    parameter logic [CW-1:0] GRP1_MASK = 32'h7FFF_0000,
    parameter int            SUM_BIT   = 31,
    parameter int            OTHER_BIT = 31,
    parameter logic [CW-1:0] THR_MASK  = 32'h0000_7FFE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [31:0]   raise_in,
    input  logic          wr_en,
    input  logic [3:0]    wr_sel,
    input  logic [31:0]   wr_data,
    input  logic          rd_en,
    input  logic [3:0]    rd_sel,
    output logic [31:0]   rd_data,
    output logic          irq_line,
    output logic [31:0]   vec_fire
);

    agg_state_t s_d, s_q;

    reg_sel_e      wsel;
    logic [CW-1:0] w1c_l, set_l, mset_l, mclr_l, raise_all;
    logic [CW-1:0] lc_n, lm_n, raised_new, route_set;
    logic          lowered, none_unmasked, rd_req;
    logic [CW-1:0] vtmp;

    assign wsel = reg_sel_e'(wr_sel);

    always_comb begin
        w1c_l  = (wr_en && wsel == SEL_LC)     ? wr_data : '0;
        set_l  = (wr_en && wsel == SEL_LC_SET) ? wr_data : '0;
        mset_l = (wr_en && wsel == SEL_LM)     ? wr_data : '0;
        mclr_l = (wr_en && wsel == SEL_LM_CLR) ? wr_data : '0;
        raise_all = raise_in | set_l;
        rd_req = rd_en && (reg_sel_e'(rd_sel) == SEL_LC);
    end

    intr_cause_agg_legacy #(.SUM_BIT(SUM_BIT)) u_legacy (
        .lc_q          (s_q.lc),
        .lm_q          (s_q.lm),
        .lam_q         (s_q.lam),
        .raise_all     (raise_all),
        .w1c           (w1c_l),
        .mset          (mset_l),
        .mclr          (mclr_l),
        .rd_req        (rd_req),
        .corr          (s_q.corr),
        .lc_d          (lc_n),
        .lm_d          (lm_n),
        .raised_new    (raised_new),
        .lowered       (lowered),
        .none_unmasked (none_unmasked)
    );

    intr_cause_agg_route #(.GRP0_MASK(GRP0_MASK), .GRP1_MASK(GRP1_MASK)) u_route (
        .en       (s_q.vmode),
        .raised   (raised_new),
        .rt       (s_q.rt),
        .set_bits (route_set)
    );

    always_comb begin
        s_d    = s_q;
        s_d.lc = lc_n;
        s_d.lm = lm_n;
        if (wr_en) begin
            unique case (wsel)
                SEL_LAM:    s_d.lam = wr_data;
                SEL_VM:     s_d.vm  = s_q.vm | wr_data;
                SEL_VM_CLR: s_d.vm  = s_q.vm & ~wr_data;
                SEL_VAC:    s_d.vac = wr_data;
                SEL_RT:     s_d.rt  = wr_data[RT_W-1:0];
                SEL_CTRL: begin
                    s_d.vmode = wr_data[0];
                    s_d.corr  = wr_data[1];
                end
                SEL_THR:    s_d.thr = wr_data & THR_MASK;
                default: ;
            endcase
        end
        vtmp = s_q.vc;
        if (wr_en && wsel == SEL_VC) begin
            vtmp = vtmp & ~wr_data;
        end
        vtmp = vtmp | route_set;
        if (!s_q.vmode && (|raised_new)) begin
            vtmp[OTHER_BIT] = 1'b1;
        end
        if (!s_q.vmode && lowered && none_unmasked) begin
            vtmp[OTHER_BIT] = 1'b0;
        end
        s_d.fire = s_q.vmode ? (vtmp & s_d.vm & ~(s_q.vc & s_q.vm)) : '0;
        s_d.vc   = vtmp & ~(s_d.fire & s_q.vac);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        unique case (reg_sel_e'(rd_sel))
            SEL_LC, SEL_LC_SET: rd_data = s_q.lc;
            SEL_LM, SEL_LM_CLR: rd_data = s_q.lm;
            SEL_LAM:            rd_data = s_q.lam;
            SEL_VC:             rd_data = s_q.vc;
            SEL_VM, SEL_VM_CLR: rd_data = s_q.vm;
            SEL_VAC:            rd_data = s_q.vac;
            SEL_RT:             rd_data = {{(CW-RT_W){1'b0}}, s_q.rt};
            SEL_CTRL:           rd_data = {{(CW-2){1'b0}}, s_q.corr, s_q.vmode};
            SEL_THR:            rd_data = s_q.thr;
            default:            rd_data = '0;
        endcase
    end

    assign irq_line = !s_q.vmode && (|(s_q.lc & s_q.lm));
    assign vec_fire = s_q.fire;

    // Summary bit tracks the other legacy causes.
    assert_summary_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.lc[SUM_BIT] == (|(s_q.lc & ~(CW'(1) << SUM_BIT))));

    // Mask-clear write removes the written bits.
    assert_mask_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wsel == SEL_LM_CLR) |=> ((s_q.lm & $past(wr_data)) == '0));

    // Fire pulses only follow per-vector mode.
    assert_fire_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|vec_fire) |-> $past(s_q.vmode));

    // Auto-clear bits are gone once their vector fired.
    assert_autoclr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|vec_fire) |-> ((s_q.vc & vec_fire & $past(s_q.vac)) == '0));

    // Read with zero mask and no concurrent raise empties the register.
    assert_rd_zero_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && s_q.lm == '0 && raise_all == '0) |=> (s_q.lc == '0));

    // Throttle keeps only its legal bits.
    assert_throttle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.thr & ~THR_MASK) == '0);

endmodule

// File: tb/intr_cause_agg_tb_top.sv
`timescale 1ns/1ps
module intr_cause_agg_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] raise_in = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        irq_line;
    logic [31:0] vec_fire;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    intr_cause_agg dut_i (
        .clk(clk), .rst_n(rst_n), .raise_in(raise_in),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .irq_line(irq_line), .vec_fire(vec_fire)
    );

    localparam logic [1:0] OP_NOP = 2'd0, OP_WR = 2'd1, OP_RS = 2'd2, OP_RD = 2'd3;
    localparam logic [3:0] S_LC = 4'd0, S_LM = 4'd2, S_LMC = 4'd3, S_LAM = 4'd4,
        S_VC = 4'd5, S_VM = 4'd6, S_VAC = 4'd8, S_RT = 4'd9, S_CTL = 4'd10, S_THR = 4'd11;
    localparam logic [4:0] K_LC = 5'd0, K_LM = 5'd2, K_LAM = 5'd4, K_VC = 5'd5,
        K_VM = 5'd6, K_VAC = 5'd8, K_RT = 5'd9, K_CTL = 5'd10, K_THR = 5'd11,
        K_LINE = 5'd16, K_FIRE = 5'd17, K_CAP = 5'd18;

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  sel;
        logic [31:0] data;
        logic [4:0]  chk;
        logic [31:0] exp;
        logic [3:0]  req;
    } step_t;

    localparam int NSTEP = 40;
    localparam step_t TAB [NSTEP] = '{
        '{OP_WR,  S_LM,  32'h5,        K_LM,   32'h5,        4'd3},  // R3 mask set
        '{OP_RS,  S_LC,  32'h4,        K_LC,   32'h8000_0004, 4'd1}, // R1 raise
        '{OP_NOP, S_LC,  32'h0,        K_LINE, 32'h1,        4'd3},  // R3 line high
        '{OP_NOP, S_LC,  32'h0,        K_VC,   32'h8000_0000, 4'd4}, // R4 OTHER set
        '{OP_RS,  S_LC,  32'h2,        K_LC,   32'h8000_0006, 4'd2}, // R2 summary
        '{OP_WR,  S_LMC, 32'h4,        K_VC,   32'h0,        4'd5},  // R5 OTHER cleared
        '{OP_NOP, S_LC,  32'h0,        K_LINE, 32'h0,        4'd3},  // R3 line low
        '{OP_RD,  S_LC,  32'h0,        K_CAP,  32'h8000_0006, 4'd9}, // R9 read value
        '{OP_NOP, S_LC,  32'h0,        K_LC,   32'h0,        4'd9},  // R9 cleared
        '{OP_WR,  S_LAM, 32'h1,        K_LAM,  32'h1,        4'd9},  // R9 automask
        '{OP_RS,  S_LC,  32'h1,        K_LINE, 32'h1,        4'd3},  // R3
        '{OP_RD,  S_LC,  32'h0,        K_CAP,  32'h8000_0001, 4'd9}, // R9
        '{OP_NOP, S_LC,  32'h0,        K_LM,   32'h0,        4'd9},  // R9 automask applied
        '{OP_NOP, S_LC,  32'h0,        K_VC,   32'h0,        4'd5},  // R5
        '{OP_RS,  S_LC,  32'h2,        K_LC,   32'h8000_0002, 4'd1}, // R1
        '{OP_RD,  S_LC,  32'h0,        K_CAP,  32'h8000_0002, 4'd9}, // R9 zero mask
        '{OP_NOP, S_LC,  32'h0,        K_LC,   32'h0,        4'd9},  // R9
        '{OP_WR,  S_CTL, 32'h2,        K_CTL,  32'h2,        4'd10}, // R10 option on
        '{OP_WR,  S_LM,  32'h1,        K_LM,   32'h1,        4'd10}, // R10
        '{OP_RS,  S_LC,  32'h1,        K_LC,   32'h8000_0001, 4'd10}, // R10
        '{OP_RD,  S_LC,  32'h0,        K_CAP,  32'h8000_0001, 4'd10}, // R10
        '{OP_NOP, S_LC,  32'h0,        K_LM,   32'h1,        4'd10}, // R10 mask kept
        '{OP_NOP, S_LC,  32'h0,        K_LC,   32'h0,        4'd10}, // R10 cleared
        '{OP_WR,  S_CTL, 32'h1,        K_VC,   32'h0,        4'd6},  // R6 vector mode
        '{OP_WR,  S_RT,  32'h8385,     K_RT,   32'h8385,     4'd6},  // R6 route
        '{OP_WR,  S_VM,  32'h28,       K_VM,   32'h28,       4'd7},  // R7
        '{OP_WR,  S_VAC, 32'h20,       K_VAC,  32'h20,       4'd8},  // R8
        '{OP_RS,  S_LC,  32'h1,        K_FIRE, 32'h20,       4'd7},  // R7 vector 5
        '{OP_NOP, S_LC,  32'h0,        K_VC,   32'h0,        4'd8},  // R8 auto-cleared
        '{OP_WR,  S_LM,  32'h1_0000,   K_LM,   32'h1_0001,   4'd3},  // R3
        '{OP_RS,  S_LC,  32'h1_0000,   K_FIRE, 32'h8,        4'd6},  // R6 group 1
        '{OP_NOP, S_LC,  32'h0,        K_VC,   32'h8,        4'd8},  // R8 kept
        '{OP_NOP, S_LC,  32'h0,        K_LINE, 32'h0,        4'd3},  // R3 vector mode
        '{OP_RS,  S_LC,  32'h1_0000,   K_FIRE, 32'h0,        4'd12}, // R12 pending
        '{OP_WR,  S_LC,  32'hFFFF_FFFF, K_LC,  32'h0,        4'd1},  // R1 clear
        '{OP_WR,  S_RT,  32'h0005,     K_RT,   32'h5,        4'd6},  // R6
        '{OP_RS,  S_LC,  32'h1,        K_FIRE, 32'h0,        4'd6},  // R6 invalid byte
        '{OP_NOP, S_LC,  32'h0,        K_VC,   32'h8,        4'd6},  // R6
        '{OP_WR,  S_THR, 32'hFFFF_FFFF, K_THR, 32'h7FFE,     4'd11}, // R11
        '{OP_WR,  S_VC,  32'h8,        K_VC,   32'h0,        4'd7}   // R7 clear
    };

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic run_step(step_t s);
        logic [31:0] cap;
        logic [31:0] got;
        @(negedge clk);
        case (s.op)
            OP_WR: begin wr_en = 1'b1; wr_sel = s.sel; wr_data = s.data; end
            OP_RS: raise_in = s.data;
            OP_RD: begin rd_en = 1'b1; rd_sel = s.sel; end
            default: ;
        endcase
        #1 cap = rd_data;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; raise_in = '0;
        if (s.chk < 5'd16) rd_sel = s.chk[3:0];
        #1;
        if (s.chk == K_LINE)      got = {31'b0, irq_line};
        else if (s.chk == K_FIRE) got = vec_fire;
        else if (s.chk == K_CAP)  got = cap;
        else                      got = rd_data;
        check($sformatf("R%0d", s.req), got, s.exp);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd_sel = S_LC;
        #1;
        check("R1 reset cause", rd_data, 32'h0);
        check("R3 reset line", {31'b0, irq_line}, 32'h0);
        check("R7 reset fire", vec_fire, 32'h0);
        for (int i = 0; i < NSTEP; i++) begin
            run_step(TAB[i]);
        end
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd_sel = S_THR;
        #1 check("R11 reset throttle", rd_data, 32'h0);
        rd_sel = S_LM;
        #1 check("R1 reset mask", rd_data, 32'h0);
        rd_sel = S_VC;
        #1 check("R1 reset ext cause", rd_data, 32'h0);
        finish_run();
    end

endmodule